// File: doc/BRIEF.md
# Streaming Instruction Cache with Per-Word Valid Bits

This block sits between an instruction fetch port and a plain word-wide memory read port. A fetch that finds its word present gets it back in the same cycle. A fetch that does not find its word starts a refill of the line. The refill begins at the requested word and moves one word at a time toward the end of the line. Each word coming back from memory is written into the cache and, if the fetch port is asking for it, handed to the fetch port in that same cycle. The fetch stage can therefore move on before the line is complete.

Every 32-bit word of a line has its own valid bit, so a line can be partly present. When a later fetch matches the tag but lands on a missing word, only the missing words are read and the words already held stay valid. The cache can be built with one or two ways. With two ways, one bit per set records which way to replace next. A synchronous flush input clears all valid bits at once and abandons any refill in progress.

Top module: `icache_stream`

## Requirements
- R1: After reset, `fetch_valid` and `mem_req` are low and no word is valid, so the first fetch of any address waits for memory.
- R2: A fetch whose tag matches a way and whose word valid bit is set raises `fetch_valid` in the same cycle as `fetch_req` and starts no memory read.
- R3: A miss at word k reads words k, k+1, ... up to the last word of the line in ascending order. Each read uses `mem_addr` = {tag, set, word, 2'b00}. Words below k are not read.
- R4: In a cycle where `mem_req` and `mem_ready` are both high and the fetch word address equals `mem_addr[ADDR_W-1:2]`, `fetch_valid` is high and `fetch_data` equals `mem_data`.
- R5: During a refill, a fetch of a word of that line that has already arrived is answered in the same cycle and adds no memory reads.
- R6: A fetch that matches the tag but finds its word invalid reads only the invalid words from that word to the end of the line. The valid words of the line stay valid.
- R7: `flush` clears every valid bit in one cycle. In that cycle `fetch_valid` is low. In the next cycle `mem_req` is low.
- R8: If `flush` falls in the same cycle that memory returns a word, the flush wins. The word is neither forwarded nor kept, and a fetch that is still waiting starts a fresh refill of its whole line from its own word.
- R9: With 2 ways, a miss with no tag match replaces the least recently used way of the set. The replacement choice is updated by every hit and every refilled word.
- R10: While `mem_req` is high and `mem_ready` is low, `mem_addr` holds its value, unless `flush` is high.
- R11: Every word returned on `fetch_data` equals the memory content at the fetched address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clear all valid bits and abandon any refill |
| fetch_req | input | 1 | Fetch request, held until `fetch_valid` |
| fetch_addr | input | ADDR_W | Byte address of the instruction word |
| fetch_valid | output | 1 | Requested word is on `fetch_data` this cycle |
| fetch_data | output | 32 | Instruction word |
| mem_req | output | 1 | Memory word read request |
| mem_addr | output | ADDR_W | Word-aligned byte address of the memory read |
| mem_ready | input | 1 | Memory returns `mem_data` and accepts the read |
| mem_data | input | 32 | Word returned by memory |

## Verification
Flush and the arrival of a refill word can land in the same cycle. The bench provokes this by watching its own memory model's latency counter and raising `flush` exactly in the cycle the model presents `mem_ready` for a fetch that is still waiting. The result is judged at the ports. `fetch_valid` must stay low in that cycle despite the matching word on `mem_data`. Afterwards the memory read counter must show the whole line being fetched again, and the scoreboard must still receive the correct word. A second overlap, a hit on an arrived word while the refill is still reading, is checked by requiring a zero-cycle answer while `mem_req` is high.

// File: rtl/icache_stream.sv
module icache_stream #(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 16,
  parameter int WAYS       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              fetch_req,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_valid,
  output logic [31:0]       fetch_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ready,
  input  logic [31:0]       mem_data
);
  localparam int OFF_W = $clog2(LINE_WORDS);
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - 2 - OFF_W - IDX_W;

  typedef enum logic {IDLE, FILL} st_t;

  logic [31:0]           data_q [WAYS][SETS][LINE_WORDS];
  logic [TAG_W-1:0]      tag_q  [WAYS][SETS];
  logic [LINE_WORDS-1:0] vld_q  [WAYS][SETS];
  logic [SETS-1:0]       lru_q;

  st_t              st;
  logic [TAG_W-1:0] r_tag;
  logic [IDX_W-1:0] r_set;
  logic [OFF_W-1:0] r_wrd;
  logic             r_way;

  wire [TAG_W-1:0] f_tag = fetch_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0] f_set = fetch_addr[2+OFF_W +: IDX_W];
  wire [OFF_W-1:0] f_wrd = fetch_addr[2 +: OFF_W];

  logic [WAYS-1:0] tag_hit, word_hit;
  logic            hit_way, match_way;

  always_comb begin
    hit_way   = 1'b0;
    match_way = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      tag_hit[w]  = tag_q[w][f_set] == f_tag;
      word_hit[w] = tag_hit[w] && vld_q[w][f_set][f_wrd];
      if (word_hit[w]) hit_way = 1'(w);
      if (tag_hit[w])  match_way = 1'(w);
    end
  end

  wire any_hit = |word_hit;
  wire any_tag = |tag_hit;
  wire victim  = (WAYS > 1) ? lru_q[f_set] : 1'b0;
  wire new_way = any_tag ? match_way : victim;

  wire cur_vld = st == FILL && vld_q[r_way][r_set][r_wrd];
  wire last    = r_wrd == OFF_W'(LINE_WORDS - 1);

  assign mem_req  = st == FILL && !cur_vld;
  assign mem_addr = {r_tag, r_set, r_wrd, 2'b00};

  wire take = mem_req && mem_ready && !flush;
  wire fwd  = take && fetch_req && fetch_addr[ADDR_W-1:2] == mem_addr[ADDR_W-1:2];
  wire miss = st == IDLE && fetch_req && !flush && !any_hit;

  assign fetch_valid = fetch_req && !flush && (any_hit || fwd);
  assign fetch_data  = fwd ? mem_data : data_q[hit_way][f_set][f_wrd];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      r_tag <= '0;
      r_set <= '0;
      r_wrd <= '0;
      r_way <= 1'b0;
      lru_q <= '0;
      for (int w = 0; w < WAYS; w++)
        for (int s = 0; s < SETS; s++) begin
          vld_q[w][s] <= '0;
          tag_q[w][s] <= '0;
        end
    end else if (flush) begin
      st <= IDLE;
      for (int w = 0; w < WAYS; w++)
        for (int s = 0; s < SETS; s++)
          vld_q[w][s] <= '0;
    end else begin
      if (miss) begin
        st    <= FILL;
        r_tag <= f_tag;
        r_set <= f_set;
        r_wrd <= f_wrd;
        r_way <= new_way;
        if (!any_tag) begin
          tag_q[new_way][f_set] <= f_tag;
          vld_q[new_way][f_set] <= '0;
        end
      end else if (st == FILL && (cur_vld || take)) begin
        if (take) begin
          vld_q[r_way][r_set][r_wrd] <= 1'b1;
          lru_q[r_set] <= ~r_way;
        end
        if (last) st <= IDLE;
        else      r_wrd <= r_wrd + 1'b1;
      end
      if (fetch_valid && any_hit && WAYS > 1) lru_q[f_set] <= ~hit_way;
    end
  end

  always_ff @(posedge clk)
    if (take) data_q[r_way][r_set][r_wrd] <= mem_data;

endmodule

// File: rtl/icache_stream_chk.sv
module icache_stream_chk #(
  parameter int ADDR_W     = 32,
  parameter int LINE_WORDS = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              fetch_req,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              fetch_valid,
  input logic [31:0]       fetch_data,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ready,
  input logic [31:0]       mem_data
);
  localparam int OFF_W = $clog2(LINE_WORDS);

  // R10
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready && !flush) |=> (mem_req && $stable(mem_addr)));

  // R7
  flush_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !fetch_valid);

  // R7
  flush_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !mem_req);

  // R4
  forward_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && !flush && fetch_req &&
     fetch_addr[ADDR_W-1:2] == mem_addr[ADDR_W-1:2])
    |-> (fetch_valid && fetch_data == mem_data));

  // R3
  seq_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ready && !flush && mem_addr[2 +: OFF_W] != OFF_W'(LINE_WORDS - 1))
    |=> mem_addr[ADDR_W-1:2] == $past(mem_addr[ADDR_W-1:2]) + 1'b1);

  // R3
  aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);

  // R2
  valid_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> fetch_req);
endmodule

bind icache_stream icache_stream_chk #(.ADDR_W(ADDR_W), .LINE_WORDS(LINE_WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_req(fetch_req),
  .fetch_addr(fetch_addr), .fetch_valid(fetch_valid), .fetch_data(fetch_data),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_data(mem_data));

// File: tb/icache_stream_bench.sv
module icache_stream_bench;
  localparam int ADDR_W = 32;
  localparam int LAT    = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              flush = 1'b0;
  logic              fetch_req = 1'b0;
  logic [ADDR_W-1:0] fetch_addr = '0;
  logic              fetch_valid;
  logic [31:0]       fetch_data;
  logic              mem_req;
  logic [ADDR_W-1:0] mem_addr;
  logic              mem_ready = 1'b0;
  logic [31:0]       mem_data = '0;

  int checks = 0, errors = 0, words_in = 0, cnt = 0;
  int wc, w0;
  bit fs, busy;
  logic [31:0] expq[$];

  icache_stream u_icache_stream (
    .clk(clk), .rst_n(rst_n), .flush(flush), .fetch_req(fetch_req),
    .fetch_addr(fetch_addr), .fetch_valid(fetch_valid), .fetch_data(fetch_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_data(mem_data));

  always #5 clk = ~clk;

  function automatic logic [31:0] ref_word(input logic [ADDR_W-1:0] a);
    return a * 32'h9E37_79B1 + 32'h7F4A_7C15;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: ready LAT+1 cycles after a read is presented
  always @(posedge clk) begin
    if (!rst_n || !mem_req || mem_ready) begin
      cnt <= 0;
      mem_ready <= 1'b0;
    end else if (cnt == LAT) begin
      mem_ready <= 1'b1;
      mem_data <= ref_word(mem_addr);
    end else cnt <= cnt + 1;
  end

  // monitor: scoreboard pop and memory traffic count
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_ready && !flush) words_in++;
    if (rst_n && fetch_valid) begin
      if (expq.size() == 0) check(1'b0, "R11 unexpected word", fetch_data, 32'h0);
      else begin
        logic [31:0] e;
        e = expq.pop_front();
        check(fetch_data == e, "R11 data", fetch_data, e);
      end
    end
  end

  task automatic fetch(input logic [ADDR_W-1:0] a);
    @(posedge clk); #1;
    expq.push_back(ref_word(a));
    fetch_req = 1'b1;
    fetch_addr = a;
    wc = 0;
    forever begin
      @(negedge clk);
      if (fetch_valid) begin
        fs = mem_req && mem_ready;
        busy = mem_req;
        break;
      end
      wc++;
    end
    @(posedge clk); #1;
    fetch_req = 1'b0;
  endtask

  task automatic settle();
    repeat (24) @(posedge clk);
  endtask

  initial begin
    #1_000_000;
    check(1'b0, "watchdog", 32'h0, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    check(!fetch_valid && !mem_req, "R1 reset outputs", {fetch_valid, mem_req}, 0);

    // R3 R4: miss in middle of a line, streamed words
    w0 = words_in;
    fetch(32'h408);
    check(wc > 0, "R1 first fetch waits", wc, 1);
    check(fs, "R4 missed word forwarded", fs, 1);
    fetch(32'h40C);
    check(fs, "R4 next word forwarded", fs, 1);
    settle();
    check(words_in - w0 == 2, "R3 words read", words_in - w0, 2);

    // R2: hit
    w0 = words_in;
    fetch(32'h408);
    check(wc == 0, "R2 hit latency", wc, 0);
    check(words_in == w0, "R2 no memory read", words_in - w0, 0);

    // R6: tag match, invalid word
    fetch(32'h400);
    settle();
    check(words_in - w0 == 2, "R6 only missing words", words_in - w0, 2);
    fetch(32'h40C);
    check(wc == 0, "R6 old word kept", wc, 0);

    // R5: arrived word during refill
    w0 = words_in;
    fetch(32'h500);
    fetch(32'h500);
    check(wc == 0 && busy, "R5 hit during refill", {wc[7:0], 7'd0, busy}, 1);
    settle();
    check(words_in - w0 == 4, "R5 no extra miss", words_in - w0, 4);

    // R2 R4: sequential stream
    for (int i = 1; i < 4; i++) begin
      fetch(32'h500 + 4 * i);
      check(wc == 0, "R2 sequential hit", wc, 0);
    end
    fetch(32'h610);
    for (int i = 1; i < 4; i++) begin
      fetch(32'h610 + 4 * i);
      check(fs, "R4 streamed word", fs, 1);
    end
    settle();

    // R9: LRU in set 2
    fetch(32'h1020); settle();
    fetch(32'h2020); settle();
    fetch(32'h1020);
    check(wc == 0, "R9 first line hit", wc, 0);
    fetch(32'h3020); settle();
    w0 = words_in;
    fetch(32'h1024);
    check(wc == 0 && words_in == w0, "R9 recently used kept", wc, 0);
    fetch(32'h2020);
    check(wc > 0, "R9 least recent evicted", wc, 1);
    settle();

    // R7: flush with a hitting request
    @(posedge clk); #1;
    expq.push_back(ref_word(32'h1024));
    fetch_req = 1'b1;
    fetch_addr = 32'h1024;
    flush = 1'b1;
    @(negedge clk);
    check(!fetch_valid, "R7 stall in flush", fetch_valid, 0);
    @(posedge clk); #1 flush = 1'b0;
    @(negedge clk);
    check(!fetch_valid, "R7 valid bits cleared", fetch_valid, 0);
    while (!fetch_valid) @(negedge clk);
    @(posedge clk); #1 fetch_req = 1'b0;
    settle();

    // R8: flush collides with returning word
    @(posedge clk); #1;
    expq.push_back(ref_word(32'h700));
    fetch_req = 1'b1;
    fetch_addr = 32'h700;
    do @(negedge clk); while (!(mem_req && !mem_ready && cnt == LAT));
    @(posedge clk); #1 flush = 1'b1;
    @(negedge clk);
    check(mem_ready && !fetch_valid, "R8 flush beats forward", {mem_ready, fetch_valid}, 2);
    @(posedge clk); #1 flush = 1'b0;
    w0 = words_in;
    while (!fetch_valid) @(negedge clk);
    @(posedge clk); #1 fetch_req = 1'b0;
    settle();
    check(words_in - w0 == 4, "R8 refill restarted", words_in - w0, 4);
    check(expq.size() == 0, "R11 all words returned", expq.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule